// File: doc/BRIEF.md
# Mixed-Width Dual-Port Bit RAM

This block is a two-port synchronous RAM that joins a bit-serial producer or consumer to a word-wide one. The wide port moves whole 16-bit words. The narrow port moves single bits. Both ports see the same storage. A narrow address is a word index with a 4-bit lane number appended below it, so each wide word spans sixteen consecutive narrow addresses.

An elaboration parameter fixes how a lane number maps to a bit of the word. With LSB-first ordering, lane k is bit k. With MSB-first ordering, lane k is bit 15-k, which amounts to inverting the lane number.

Each port has its own clock, enable and write enable. Both ports register their read data. A narrow write changes exactly one bit of the stored word. The storage is built so that each port writes only its own flops: every logical bit is the XOR of one flop per port. This lets two independent clocks write the same storage without any flop having two drivers.

Top module: `mixed_width_bitram`

## Requirements
- R1: While `rst_n` is low, and after it is released until the first enabled read, both `w_rdata` and `n_rdata` are zero.
- R2: A wide read of word `a` with `w_en`=1 and `w_we`=0 returns the stored word on `w_rdata` after the next rising `w_clk`. Before that edge `w_rdata` still shows the previous result.
- R3: A narrow write changes only the one addressed bit of the stored word. The other fifteen bits of that word, as read from the wide port, are unchanged.
- R4: With `ORDER` = LSB-first, narrow address `{word, lane}` refers to bit `lane` of word `word`. Lane 0 is bit 0 and lane 15 is bit 15.
- R5: With `ORDER` = MSB-first, narrow address `{word, lane}` refers to bit `15 - lane`. Lane 0 is bit 15 and lane 15 is bit 0.
- R6: A narrow read returns on `n_rdata`, one `n_clk` edge later, the bit of the stored word that R4/R5 select. That word may have been written by either port.
- R7: When a port reads and writes the same address in one enabled cycle, its read data is the content from before that write.
- R8: With a port's enable low, that port neither writes (whatever its write enable and data) nor updates its read data.
- R9: With enable high and write enable low, a port reads only. The stored contents are unchanged whatever is on its write data input.
- R10: The narrow address bits above the low four select the word. Different words hold independent contents.
- R11: Writes by both ports in the same cycle to different words both take effect. Writes by both ports to the same word in the same cycle are not allowed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rst_n | input | 1 | Asynchronous active-low clear of both read-data registers |
| w_clk | input | 1 | Wide-port clock |
| w_en | input | 1 | Wide-port enable |
| w_we | input | 1 | Wide-port write enable (qualified by `w_en`) |
| w_addr | input | WORD_AW | Wide-port word address |
| w_wdata | input | WIDE_W | Wide-port write word |
| w_rdata | output | WIDE_W | Wide-port registered read word |
| n_clk | input | 1 | Narrow-port clock |
| n_en | input | 1 | Narrow-port enable |
| n_we | input | 1 | Narrow-port write enable (qualified by `n_en`) |
| n_addr | input | WORD_AW+4 | Narrow-port address: word index above, lane number in the low 4 bits |
| n_wdata | input | 1 | Narrow-port write bit |
| n_rdata | output | 1 | Narrow-port registered read bit |

## Verification
A wrong lane decode shows on the first wide read after a narrow write. Either the set bit sits at the mirrored position, or a neighbouring bit of the word has changed, so the fault is visible two clock edges after the narrow write. A stale or corrupt flop in either XOR bank flips the logical bit seen by both ports at once. The next read of that word from either side shows it one edge later. A read register that loads on the wrong condition shows up in the same cycle: `w_rdata` or `n_rdata` changes while the port is idle, or shows the freshly written value instead of the old one.

// File: rtl/bitram_pkg.sv
package bitram_pkg;

    // Mapping from narrow-port lane number to bit position in the wide word.
    typedef enum logic {
        ORDER_LSB_FIRST = 1'b0,
        ORDER_MSB_FIRST = 1'b1
    } lane_order_e;

endpackage

// File: rtl/lane_decode.sv
module lane_decode
    import bitram_pkg::*;
#(
    parameter int          WIDE_W = 16,
    parameter lane_order_e ORDER  = ORDER_LSB_FIRST,
    localparam int         LANE_AW = $clog2(WIDE_W)
) (
    input  logic [LANE_AW-1:0] lane_addr,
    output logic [LANE_AW-1:0] lane_idx,
    output logic [WIDE_W-1:0]  lane_onehot
);

    // Bit order picked at elaboration: identity or inverted lane number.
    generate
        if (ORDER == ORDER_MSB_FIRST) begin : g_msb_first
            assign lane_idx = lane_addr ^ {LANE_AW{1'b1}};
        end else begin : g_lsb_first
            assign lane_idx = lane_addr;
        end
    endgenerate

    // One-hot write mask, one comparator per bit.
    for (genvar i = 0; i < WIDE_W; i++) begin : g_mask
        assign lane_onehot[i] = (lane_idx == LANE_AW'(i));
    end

endmodule

// File: rtl/xor_bank.sv
// One port's private copy of the storage. The logical content of a word is
// this bank XOR the peer bank, so only the owning clock ever writes here.
module xor_bank #(
    parameter int  WIDE_W  = 16,
    parameter int  WORD_AW = 4,
    localparam int DEPTH   = 1 << WORD_AW
) (
    input  logic               clk,
    input  logic               wr_en,
    input  logic [WORD_AW-1:0] wr_word,
    input  logic [WIDE_W-1:0]  wr_mask,
    input  logic [WIDE_W-1:0]  wr_val,
    input  logic [WIDE_W-1:0]  peer_at_wr,
    input  logic [WORD_AW-1:0] own_look_word,
    output logic [WIDE_W-1:0]  own_look_q,
    input  logic [WORD_AW-1:0] peer_look_word,
    output logic [WIDE_W-1:0]  peer_look_q
);

    typedef logic [WIDE_W-1:0] word_t;

    word_t mem_q [DEPTH];
    word_t mem_d [DEPTH];

    always_comb begin
        mem_d = mem_q;
        if (wr_en) begin
            // Store value ^ peer so the XOR of both banks equals value.
            mem_d[wr_word] = (mem_q[wr_word] & ~wr_mask)
                           | ((wr_val ^ peer_at_wr) & wr_mask);
        end
    end

    always_ff @(posedge clk) begin
        mem_q <= mem_d;
    end

    assign own_look_q  = mem_q[own_look_word];
    assign peer_look_q = mem_q[peer_look_word];

endmodule

// File: rtl/read_stage.sv
module read_stage #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] q_d;
    logic [W-1:0] q_q;

    always_comb begin
        q_d = en ? d : q_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_q <= '0;
        else        q_q <= q_d;
    end

    assign q = q_q;

endmodule

// File: rtl/mixed_width_bitram.sv
module mixed_width_bitram
    import bitram_pkg::*;
#(
    parameter int          WIDE_W  = 16,
    parameter int          WORD_AW = 4,
    parameter lane_order_e ORDER   = ORDER_LSB_FIRST,
    localparam int         LANE_AW   = $clog2(WIDE_W),
    localparam int         NARROW_AW = WORD_AW + LANE_AW
) (
    input  logic                 rst_n,
    input  logic                 w_clk,
    input  logic                 w_en,
    input  logic                 w_we,
    input  logic [WORD_AW-1:0]   w_addr,
    input  logic [WIDE_W-1:0]    w_wdata,
    output logic [WIDE_W-1:0]    w_rdata,
    input  logic                 n_clk,
    input  logic                 n_en,
    input  logic                 n_we,
    input  logic [NARROW_AW-1:0] n_addr,
    input  logic                 n_wdata,
    output logic [0:0]           n_rdata
);

    logic [WORD_AW-1:0] n_word;
    logic [LANE_AW-1:0] n_lane;
    logic [LANE_AW-1:0] lane_idx;
    logic [WIDE_W-1:0]  lane_mask;

    logic [WIDE_W-1:0]  bw_own, bw_peer;   // wide bank at w word / n word
    logic [WIDE_W-1:0]  bn_own, bn_peer;   // narrow bank at n word / w word
    logic [WIDE_W-1:0]  w_cur, n_cur;
    logic [0:0]         n_bit;

    assign n_word = n_addr[NARROW_AW-1:LANE_AW];
    assign n_lane = n_addr[LANE_AW-1:0];

    lane_decode #(
        .WIDE_W (WIDE_W),
        .ORDER  (ORDER)
    ) u_lane (
        .lane_addr   (n_lane),
        .lane_idx    (lane_idx),
        .lane_onehot (lane_mask)
    );

    xor_bank #(
        .WIDE_W  (WIDE_W),
        .WORD_AW (WORD_AW)
    ) u_bank_w (
        .clk            (w_clk),
        .wr_en          (w_en & w_we),
        .wr_word        (w_addr),
        .wr_mask        ({WIDE_W{1'b1}}),
        .wr_val         (w_wdata),
        .peer_at_wr     (bn_peer),
        .own_look_word  (w_addr),
        .own_look_q     (bw_own),
        .peer_look_word (n_word),
        .peer_look_q    (bw_peer)
    );

    xor_bank #(
        .WIDE_W  (WIDE_W),
        .WORD_AW (WORD_AW)
    ) u_bank_n (
        .clk            (n_clk),
        .wr_en          (n_en & n_we),
        .wr_word        (n_word),
        .wr_mask        (lane_mask),
        .wr_val         ({WIDE_W{n_wdata}}),
        .peer_at_wr     (bw_peer),
        .own_look_word  (n_word),
        .own_look_q     (bn_own),
        .peer_look_word (w_addr),
        .peer_look_q    (bn_peer)
    );

    // Logical content seen by each port, before any write at this edge.
    assign w_cur    = bw_own ^ bn_peer;
    assign n_cur    = bn_own ^ bw_peer;
    assign n_bit[0] = n_cur[lane_idx];

    read_stage #(.W(WIDE_W)) u_rd_w (
        .clk   (w_clk),
        .rst_n (rst_n),
        .en    (w_en),
        .d     (w_cur),
        .q     (w_rdata)
    );

    read_stage #(.W(1)) u_rd_n (
        .clk   (n_clk),
        .rst_n (rst_n),
        .en    (n_en),
        .d     (n_bit),
        .q     (n_rdata)
    );

endmodule

// File: rtl/mixed_width_bitram_chk.sv
module mixed_width_bitram_chk #(
    parameter int  WIDE_W      = 16,
    parameter int  WORD_AW     = 4,
    parameter bit  CLOCKS_TIED = 1'b1,
    localparam int LANE_AW     = $clog2(WIDE_W),
    localparam int NARROW_AW   = WORD_AW + LANE_AW
) (
    input logic                 rst_n,
    input logic                 w_clk,
    input logic                 w_en,
    input logic                 w_we,
    input logic [WORD_AW-1:0]   w_addr,
    input logic [WIDE_W-1:0]    w_wdata,
    input logic [WIDE_W-1:0]    w_rdata,
    input logic                 n_clk,
    input logic                 n_en,
    input logic                 n_we,
    input logic [NARROW_AW-1:0] n_addr,
    input logic                 n_wdata,
    input logic [0:0]           n_rdata
);

    // R1: read registers are clear during reset
    always @(posedge w_clk) begin
        if (!rst_n) begin
            assert_rst_clear_wide_R1: assert (w_rdata == '0)
                else $error("wide read data not clear in reset");
        end
    end
    always @(posedge n_clk) begin
        if (!rst_n) begin
            assert_rst_clear_narrow_R1: assert (n_rdata == 1'b0)
                else $error("narrow read data not clear in reset");
        end
    end

    // R8: idle port keeps its read data
    assert_idle_hold_wide_R8: assert property (@(posedge w_clk) disable iff (!rst_n)
        !w_en |=> $stable(w_rdata));
    assert_idle_hold_narrow_R8: assert property (@(posedge n_clk) disable iff (!rst_n)
        !n_en |=> $stable(n_rdata));

    // Cross-port properties sample both ports on one clock.
    generate
        if (CLOCKS_TIED) begin : g_tied
            logic [1:0] cyc_q;
            always_ff @(posedge w_clk or negedge rst_n) begin
                if (!rst_n)              cyc_q <= 2'd0;
                else if (cyc_q != 2'd3)  cyc_q <= cyc_q + 2'd1;
            end

            // R11: no same-word writes from both ports in one cycle
            assert_no_collision_R11: assert property (@(posedge w_clk) disable iff (!rst_n)
                !(w_en && w_we && n_en && n_we && (w_addr == n_addr[NARROW_AW-1:LANE_AW])));

            // R2: wide write followed by wide read of the same word
            assert_wide_readback_R2: assert property (@(posedge w_clk) disable iff (!rst_n)
                (cyc_q != 2'd0) && $past(w_en && w_we) && w_en && !w_we
                && (w_addr == $past(w_addr)) && !$past(n_en && n_we)
                |=> w_rdata == $past(w_wdata, 2));

            // R7: back-to-back wide writes to one word return the older word
            assert_wide_rbw_R7: assert property (@(posedge w_clk) disable iff (!rst_n)
                (cyc_q != 2'd0) && $past(w_en && w_we) && w_en && w_we
                && (w_addr == $past(w_addr)) && !$past(n_en && n_we)
                |=> w_rdata == $past(w_wdata, 2));

            // R6: narrow write followed by narrow read of the same bit
            assert_narrow_readback_R6: assert property (@(posedge w_clk) disable iff (!rst_n)
                (cyc_q != 2'd0) && $past(n_en && n_we) && n_en
                && (n_addr == $past(n_addr)) && !$past(w_en && w_we)
                |=> n_rdata[0] == $past(n_wdata, 2));
        end
    endgenerate

endmodule

bind mixed_width_bitram mixed_width_bitram_chk #(
    .WIDE_W  (WIDE_W),
    .WORD_AW (WORD_AW)
) u_chk (
    .rst_n   (rst_n),
    .w_clk   (w_clk),
    .w_en    (w_en),
    .w_we    (w_we),
    .w_addr  (w_addr),
    .w_wdata (w_wdata),
    .w_rdata (w_rdata),
    .n_clk   (n_clk),
    .n_en    (n_en),
    .n_we    (n_we),
    .n_addr  (n_addr),
    .n_wdata (n_wdata),
    .n_rdata (n_rdata)
);

// File: tb/sim_mixed_width_bitram.sv
module sim_mixed_width_bitram;
    import bitram_pkg::*;

    localparam int WIDE_W  = 16;
    localparam int WORD_AW = 4;
    localparam int NAW     = WORD_AW + 4;
    localparam int DEPTH   = 1 << WORD_AW;

    logic clk = 1'b0;
    always #4 clk = ~clk;   // 125 MHz, shared by both ports

    logic               rst_n;
    logic               w_en, w_we, n_en, n_we, n_wdata;
    logic [WORD_AW-1:0] w_addr;
    logic [WIDE_W-1:0]  w_wdata;
    logic [NAW-1:0]     n_addr;
    logic [WIDE_W-1:0]  w_rd0, w_rd1;
    logic [0:0]         n_rd0, n_rd1;

    mixed_width_bitram #(.WIDE_W(WIDE_W), .WORD_AW(WORD_AW), .ORDER(ORDER_LSB_FIRST)) u0 (
        .rst_n(rst_n), .w_clk(clk), .w_en(w_en), .w_we(w_we), .w_addr(w_addr),
        .w_wdata(w_wdata), .w_rdata(w_rd0), .n_clk(clk), .n_en(n_en), .n_we(n_we),
        .n_addr(n_addr), .n_wdata(n_wdata), .n_rdata(n_rd0));

    mixed_width_bitram #(.WIDE_W(WIDE_W), .WORD_AW(WORD_AW), .ORDER(ORDER_MSB_FIRST)) u1 (
        .rst_n(rst_n), .w_clk(clk), .w_en(w_en), .w_we(w_we), .w_addr(w_addr),
        .w_wdata(w_wdata), .w_rdata(w_rd1), .n_clk(clk), .n_en(n_en), .n_we(n_we),
        .n_addr(n_addr), .n_wdata(n_wdata), .n_rdata(n_rd1));

    logic [15:0] ref0 [DEPTH];   // LSB-first model
    logic [15:0] ref1 [DEPTH];   // MSB-first model
    int  n_cmp = 0;
    int  n_bad = 0;
    bit  finished = 1'b0;

    task automatic check16(string req, string what, logic [15:0] act, logic [15:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic check1(string req, string what, logic act, logic exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic go_idle();
        w_en = 1'b0; w_we = 1'b0; n_en = 1'b0; n_we = 1'b0;
    endtask

    task automatic ref_wide(logic [3:0] a, logic [15:0] d);
        ref0[a] = d;
        ref1[a] = d;
    endtask

    task automatic ref_narrow(logic [7:0] a, logic b);
        ref0[a[7:4]][a[3:0]]          = b;
        ref1[a[7:4]][4'd15 - a[3:0]]  = b;
    endtask

    task automatic wide_write(logic [3:0] a, logic [15:0] d);
        w_en = 1'b1; w_we = 1'b1; w_addr = a; w_wdata = d;
        tick();
        ref_wide(a, d);
        w_en = 1'b0; w_we = 1'b0;
    endtask

    task automatic narrow_write(logic [7:0] a, logic b);
        n_en = 1'b1; n_we = 1'b1; n_addr = a; n_wdata = b;
        tick();
        ref_narrow(a, b);
        n_en = 1'b0; n_we = 1'b0;
    endtask

    task automatic wide_read_chk(string req, logic [3:0] a);
        w_en = 1'b1; w_we = 1'b0; w_addr = a;
        tick();
        check16(req, "u0 wide read", w_rd0, ref0[a]);
        check16(req, "u1 wide read", w_rd1, ref1[a]);
        w_en = 1'b0;
    endtask

    task automatic narrow_read_chk(string req, logic [7:0] a);
        n_en = 1'b1; n_we = 1'b0; n_addr = a;
        tick();
        check1(req, "u0 narrow read", n_rd0[0], ref0[a[7:4]][a[3:0]]);
        check1(req, "u1 narrow read", n_rd1[0], ref1[a[7:4]][4'd15 - a[3:0]]);
        n_en = 1'b0;
    endtask

    // R1: outputs clear after reset
    task automatic t_reset();
        check16("R1", "u0 wide after reset", w_rd0, 16'h0000);
        check16("R1", "u1 wide after reset", w_rd1, 16'h0000);
        check1("R1", "u0 narrow after reset", n_rd0[0], 1'b0);
        check1("R1", "u1 narrow after reset", n_rd1[0], 1'b0);
    endtask

    // R2, R10: fill every word, read back, check one-cycle latency
    task automatic t_wide_basic();
        for (int i = 0; i < DEPTH; i++) begin
            logic [3:0] k = 4'(i);
            wide_write(k, {k, ~k, k ^ 4'h5, k + 4'h3});
        end
        for (int i = 0; i < DEPTH; i++) wide_read_chk("R10", 4'(i));
        wide_read_chk("R2", 4'd4);
        w_en = 1'b1; w_we = 1'b0; w_addr = 4'd5;
        #1;
        check16("R2", "u0 before edge holds old", w_rd0, ref0[4]);
        tick();
        check16("R2", "u0 after edge", w_rd0, ref0[5]);
        w_en = 1'b0;
    endtask

    // R3, R4, R5: lane-to-bit mapping and single-bit effect
    task automatic t_narrow_order();
        wide_write(4'd9, 16'h0000);
        narrow_write({4'd9, 4'd0}, 1'b1);
        wide_read_chk("R3", 4'd9);
        check16("R4", "lane 0 lsb-first", w_rd0, 16'h0001);
        check16("R5", "lane 0 msb-first", w_rd1, 16'h8000);
        narrow_write({4'd9, 4'd15}, 1'b1);
        wide_read_chk("R3", 4'd9);
        check16("R4", "lane 15 lsb-first", w_rd0, 16'h8001);
        check16("R5", "lane 15 msb-first", w_rd1, 16'h8001);
        narrow_write({4'd9, 4'd6}, 1'b1);
        wide_read_chk("R3", 4'd9);
        check16("R4", "lane 6 lsb-first", w_rd0, 16'h8041);
        check16("R5", "lane 6 msb-first", w_rd1, 16'h8201);
        wide_write(4'd10, 16'hFFFF);
        narrow_write({4'd10, 4'd3}, 1'b0);
        wide_read_chk("R3", 4'd10);
        check16("R3", "clear lane 3 lsb-first", w_rd0, 16'hFFF7);
        check16("R3", "clear lane 3 msb-first", w_rd1, 16'hEFFF);
    endtask

    // R6: narrow reads of a wide-written word
    task automatic t_narrow_read();
        wide_write(4'd11, 16'hA5C3);
        narrow_read_chk("R6", {4'd11, 4'd0});
        check1("R6", "u0 lane 0", n_rd0[0], 1'b1);
        check1("R6", "u1 lane 0", n_rd1[0], 1'b1);
        narrow_read_chk("R6", {4'd11, 4'd1});
        check1("R6", "u0 lane 1", n_rd0[0], 1'b1);
        check1("R6", "u1 lane 1", n_rd1[0], 1'b0);
        for (int l = 2; l < 16; l++) narrow_read_chk("R6", {4'd11, 4'(l)});
    endtask

    // R7: read-before-write on each port
    task automatic t_rbw();
        w_en = 1'b1; w_we = 1'b1; w_addr = 4'd12; w_wdata = 16'h1234;
        tick();
        check16("R7", "u0 first write old", w_rd0, ref0[12]);
        ref_wide(4'd12, 16'h1234);
        w_wdata = 16'hABCD;
        tick();
        check16("R7", "u0 second write", w_rd0, 16'h1234);
        check16("R7", "u1 second write", w_rd1, 16'h1234);
        ref_wide(4'd12, 16'hABCD);
        w_en = 1'b0; w_we = 1'b0;
        n_en = 1'b1; n_we = 1'b1; n_addr = {4'd12, 4'd2}; n_wdata = 1'b0;
        tick();
        check1("R7", "u0 narrow first write old", n_rd0[0], ref0[12][2]);
        check1("R7", "u1 narrow first write old", n_rd1[0], ref1[12][13]);
        ref_narrow({4'd12, 4'd2}, 1'b0);
        n_wdata = 1'b1;
        tick();
        check1("R7", "u0 narrow second write", n_rd0[0], 1'b0);
        check1("R7", "u1 narrow second write", n_rd1[0], 1'b0);
        ref_narrow({4'd12, 4'd2}, 1'b1);
        go_idle();
        wide_read_chk("R7", 4'd12);
    endtask

    // R8: disabled ports ignore writes and hold read data
    task automatic t_idle();
        logic [15:0] hold0;
        logic        nhold0;
        wide_read_chk("R8", 4'd12);
        narrow_read_chk("R8", {4'd12, 4'd5});
        hold0  = w_rd0;
        nhold0 = n_rd0[0];
        w_en = 1'b0; w_we = 1'b1; w_addr = 4'd12; w_wdata = ~ref0[12];
        n_en = 1'b0; n_we = 1'b1; n_addr = {4'd12, 4'd5}; n_wdata = ~ref0[12][5];
        tick();
        tick();
        check16("R8", "u0 wide held", w_rd0, hold0);
        check1("R8", "u0 narrow held", n_rd0[0], nhold0);
        go_idle();
        wide_read_chk("R8", 4'd12);
    endtask

    // R9: enabled read-only cycles leave contents alone
    task automatic t_readonly();
        w_en = 1'b1; w_we = 1'b0; w_addr = 4'd13; w_wdata = ~ref0[13];
        n_en = 1'b1; n_we = 1'b0; n_addr = {4'd14, 4'd9}; n_wdata = ~ref0[14][9];
        tick();
        check16("R9", "u0 read-only word", w_rd0, ref0[13]);
        check1("R9", "u0 read-only bit", n_rd0[0], ref0[14][9]);
        go_idle();
        wide_read_chk("R9", 4'd13);
        wide_read_chk("R9", 4'd14);
    endtask

    // R11: simultaneous writes to different words
    task automatic t_parallel();
        logic nb;
        nb = ~ref0[7][4];
        w_en = 1'b1; w_we = 1'b1; w_addr = 4'd3; w_wdata = 16'h5A5A;
        n_en = 1'b1; n_we = 1'b1; n_addr = {4'd7, 4'd4}; n_wdata = nb;
        tick();
        ref_wide(4'd3, 16'h5A5A);
        ref_narrow({4'd7, 4'd4}, nb);
        go_idle();
        wide_read_chk("R11", 4'd3);
        wide_read_chk("R11", 4'd7);
        narrow_read_chk("R11", {4'd7, 4'd4});
    endtask

    initial begin
        #(8 * 50000);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        go_idle();
        w_addr = '0; w_wdata = '0; n_addr = '0; n_wdata = 1'b0;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        t_reset();
        t_wide_basic();
        t_narrow_order();
        t_narrow_read();
        t_rbw();
        t_idle();
        t_readonly();
        t_parallel();
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule